// File: doc/BRIEF.md
# Data Address Generation Unit

This block forms the effective data-space address for the load, store and I/O-port instructions of a small 8-bit controller. It takes an addressing-mode code and its operands: a 16-bit absolute operand, a 6-bit immediate field, a pointer select and the current value of the selected 16-bit pointer. From these it produces the address the data path should access. For the auto-modifying modes it also produces the new pointer value, which it hands back to the register file one clock later.

The same address is decoded against a fixed data map. The map has four windows: the working registers, a 64-entry I/O-port window, an extended I/O window that only load/store modes can reach, and internal SRAM whose length is set by a parameter. A one-hot select names the window that was hit. An address past the end of SRAM raises an out-of-range flag instead. Illegal combinations select nothing and write nothing back: these are displacement with the X pointer, the reserved pointer code, and the reserved mode codes.

Instruction decode, the memories and the register file are outside this block. The register file uses `ptr_wb_en`, `ptr_wb_reg` and `ptr_wb_val` to store the pointer pair.

Top module: `data_addr_gen`

## Requirements
- R1: Mode code 0 (absolute) drives `eff_addr` equal to `abs_addr` for any 16-bit value, ignores the pointer inputs, and causes no write-back.
- R2: Mode code 1 (pointer) drives `eff_addr` equal to `ptr_val` and causes no write-back.
- R3: Mode code 2 (pointer plus offset) drives `eff_addr` to `ptr_val + imm6`, with `imm6` unsigned (0..63) and the sum taken modulo 2^16. It is legal only with pointer code 1 (Y) or 2 (Z). With code 0 (X) it raises `mode_illegal`, selects no region and writes nothing back.
- R4: Mode code 3 (pre-decrement) drives `eff_addr` to `ptr_val - 1` modulo 2^16 and writes that same value back.
- R5: Mode code 4 (post-increment) drives `eff_addr` to the unchanged `ptr_val` and writes back `ptr_val + 1` modulo 2^16.
- R6: Write-back is registered. `ptr_wb_en` is high for exactly the one cycle after an accepted auto-modifying access, and is low after reset. `ptr_wb_reg` then names the even (low-byte) register of the pair: 26 for X (code 0), 28 for Y (code 1), 30 for Z (code 2).
- R7: Mode code 5 (I/O port) drives `eff_addr` to `imm6 + 0x20`, which always lands in the I/O-port window. It ignores the pointer inputs and causes no write-back.
- R8: `region_sel` is one-hot. Bit 0 means working registers (0x000–0x01F). Bit 1 means I/O-port window (0x020–0x05F). Bit 2 means extended I/O (0x060–0x0FF). Bit 3 means SRAM (0x100 up to 0x100 + `SRAM_BYTES` - 1).
- R9: An address at or above 0x100 + `SRAM_BYTES` raises `out_of_range` and leaves `region_sel` at zero. The write-back of an auto-modifying mode still takes place.
- R10: While `acc_valid` is low, `region_sel`, `out_of_range` and `mode_illegal` are all zero, and no write-back follows in the next cycle.
- R11: Mode codes 6 and 7 are reserved. So is pointer code 3 in any pointer mode. Either one raises `mode_illegal`, selects no region and writes nothing back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mode | input | 3 | Addressing-mode code (0..5, 6 and 7 reserved) |
| abs_addr | input | 16 | Absolute address operand |
| imm6 | input | 6 | Unsigned offset or I/O port number |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 reserved |
| ptr_val | input | 16 | Current value of the selected pointer |
| eff_addr | output | 16 | Effective data-space address |
| region_sel | output | 4 | One-hot region select |
| out_of_range | output | 1 | Address beyond the end of SRAM |
| mode_illegal | output | 1 | Illegal mode or pointer combination |
| ptr_wb_en | output | 1 | Pointer write-back strobe (one cycle after the access) |
| ptr_wb_sel | output | 2 | Pointer being written back |
| ptr_wb_reg | output | 5 | Index of the low-byte register of the pair |
| ptr_wb_val | output | 16 | New pointer value |

## Verification
Every cycle, the assertions check that the region select is one-hot and is never raised together with the out-of-range flag. They check that an idle cycle selects nothing, that the I/O-port mode always lands in its window, and that an out-of-range address never selects a region. They also check that each auto-modifying access is followed one cycle later by a write-back of the value the mode calls for, and that the other modes never cause one. The bench scenarios cover the rest: the exact region boundaries at 0x1F/0x20, 0x5F/0x60 and 0xFF/0x100 and at the end of SRAM, the 16-bit wrap of offset, decrement and increment, the low-byte register index for each pointer, and the handling of reserved codes.

// File: rtl/dagu_pkg.sv
package dagu_pkg;

    typedef enum logic [2:0] {
        MODE_ABS     = 3'd0,
        MODE_PTR     = 3'd1,
        MODE_OFS     = 3'd2,
        MODE_PREDEC  = 3'd3,
        MODE_POSTINC = 3'd4,
        MODE_PORT    = 3'd5,
        MODE_RSV6    = 3'd6,
        MODE_RSV7    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        PSEL_X   = 2'd0,
        PSEL_Y   = 2'd1,
        PSEL_Z   = 2'd2,
        PSEL_RSV = 2'd3
    } psel_e;

    localparam int          ADDR_W     = 16;
    localparam int          IMM_W      = 6;
    localparam int          REGION_N   = 4;
    localparam logic [15:0] PORT_BASE  = 16'h0020;
    localparam logic [15:0] XIO_BASE   = 16'h0060;
    localparam logic [15:0] SRAM_BASE  = 16'h0100;
    localparam int unsigned PAIR_BASE  = 26;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic              wb_need;
        logic [ADDR_W-1:0] wb_val;
        logic              illegal;
    } calc_s;

    // Index of the even register holding the low byte of the pointer pair
    function automatic logic [4:0] pair_low_reg(input psel_e s);
        return 5'(PAIR_BASE + 2 * int'(s));
    endfunction

    // Lower bound (inclusive) of region i, 17 bits to hold the SRAM end
    function automatic logic [16:0] region_lo(input int i);
        case (i)
            0:       return 17'h00000;
            1:       return {1'b0, PORT_BASE};
            2:       return {1'b0, XIO_BASE};
            default: return {1'b0, SRAM_BASE};
        endcase
    endfunction

    // Upper bound (exclusive) of region i
    function automatic logic [16:0] region_hi(input int i, input int unsigned sram_bytes);
        case (i)
            0:       return {1'b0, PORT_BASE};
            1:       return {1'b0, XIO_BASE};
            2:       return {1'b0, SRAM_BASE};
            default: return 17'({1'b0, SRAM_BASE} + 17'(sram_bytes));
        endcase
    endfunction

endpackage

// File: rtl/dagu_calc.sv
module dagu_calc
    import dagu_pkg::*;
(
    input  amode_e            mode,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [IMM_W-1:0]  imm,
    input  psel_e             sel,
    input  logic [ADDR_W-1:0] ptr,
    output calc_s             res
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] imm_ext;
    logic              sel_ok;

    assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm};
    assign sel_ok  = (sel != PSEL_RSV);

    always_comb begin
        res = '0;
        unique case (mode)
            MODE_ABS: begin
                res.ea = abs_addr;
            end
            MODE_PTR: begin
                res.ea      = ptr;
                res.illegal = !sel_ok;
            end
            MODE_OFS: begin
                res.ea      = ptr + imm_ext;
                res.illegal = !sel_ok || (sel == PSEL_X);
            end
            MODE_PREDEC: begin
                res.ea      = ptr - ONE;
                res.wb_need = 1'b1;
                res.wb_val  = ptr - ONE;
                res.illegal = !sel_ok;
            end
            MODE_POSTINC: begin
                res.ea      = ptr;
                res.wb_need = 1'b1;
                res.wb_val  = ptr + ONE;
                res.illegal = !sel_ok;
            end
            MODE_PORT: begin
                res.ea = PORT_BASE + imm_ext;
            end
            default: begin
                res.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dagu_region_dec.sv
module dagu_region_dec
    import dagu_pkg::*;
#(
    parameter int unsigned SRAM_BYTES = 2048
) (
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [REGION_N-1:0] sel,
    output logic                oor
);
    localparam logic [16:0] MAP_END = region_hi(REGION_N - 1, SRAM_BYTES);

    logic [16:0] addr_x;
    assign addr_x = {1'b0, addr};

    for (genvar g = 0; g < REGION_N; g++) begin : g_win
        localparam logic [16:0] LO = region_lo(g);
        localparam logic [16:0] HI = region_hi(g, SRAM_BYTES);
        assign sel[g] = en && (addr_x >= LO) && (addr_x < HI);
    end

    assign oor = en && (addr_x >= MAP_END);
endmodule

// File: rtl/dagu_wb_reg.sv
module dagu_wb_reg
    import dagu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  psel_e             sel_in,
    input  logic [ADDR_W-1:0] val_in,
    output logic              wb_en,
    output psel_e             wb_sel,
    output logic [4:0]        wb_reg,
    output logic [ADDR_W-1:0] wb_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en  <= 1'b0;
            wb_sel <= PSEL_X;
            wb_reg <= '0;
            wb_val <= '0;
        end else begin
            wb_en <= load;
            if (load) begin
                wb_sel <= sel_in;
                wb_reg <= pair_low_reg(sel_in);
                wb_val <= val_in;
            end
        end
    end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
    import dagu_pkg::*;
#(
    parameter int unsigned SRAM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic [2:0]  acc_mode,
    input  logic [15:0] abs_addr,
    input  logic [5:0]  imm6,
    input  logic [1:0]  ptr_sel,
    input  logic [15:0] ptr_val,
    output logic [15:0] eff_addr,
    output logic [3:0]  region_sel,
    output logic        out_of_range,
    output logic        mode_illegal,
    output logic        ptr_wb_en,
    output logic [1:0]  ptr_wb_sel,
    output logic [4:0]  ptr_wb_reg,
    output logic [15:0] ptr_wb_val
);
    calc_s  calc;
    psel_e  sel_e;
    psel_e  wb_sel_e;
    logic   decode_en;
    logic   wb_load;

    assign sel_e = psel_e'(ptr_sel);

    dagu_calc u_calc (
        .mode     (amode_e'(acc_mode)),
        .abs_addr (abs_addr),
        .imm      (imm6),
        .sel      (sel_e),
        .ptr      (ptr_val),
        .res      (calc)
    );

    assign decode_en = acc_valid && !calc.illegal;

    dagu_region_dec #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
        .en   (decode_en),
        .addr (calc.ea),
        .sel  (region_sel),
        .oor  (out_of_range)
    );

    assign wb_load = decode_en && calc.wb_need;

    dagu_wb_reg u_wb (
        .clk    (clk),
        .rst    (rst),
        .load   (wb_load),
        .sel_in (sel_e),
        .val_in (calc.wb_val),
        .wb_en  (ptr_wb_en),
        .wb_sel (wb_sel_e),
        .wb_reg (ptr_wb_reg),
        .wb_val (ptr_wb_val)
    );

    assign ptr_wb_sel   = ptr_wb_sel_w(wb_sel_e);
    assign eff_addr     = calc.ea;
    assign mode_illegal = acc_valid && calc.illegal;

    function automatic logic [1:0] ptr_wb_sel_w(input psel_e s);
        return 2'(s);
    endfunction
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
    parameter int unsigned SRAM_BYTES = 2048
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [2:0]  acc_mode,
    input logic [1:0]  ptr_sel,
    input logic [15:0] ptr_val,
    input logic [15:0] eff_addr,
    input logic [3:0]  region_sel,
    input logic        out_of_range,
    input logic        mode_illegal,
    input logic        ptr_wb_en,
    input logic [15:0] ptr_wb_val
);
    localparam logic [16:0] END_X = 17'(17'h100 + 17'(SRAM_BYTES));

    logic legal_acc;
    assign legal_acc = acc_valid && !mode_illegal;

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_sel) && !(out_of_range && (region_sel != 4'b0))); // R8

    AST_OOR_FLAG: assert property (@(posedge clk) disable iff (rst)
        legal_acc && ({1'b0, eff_addr} >= END_X) |-> out_of_range && region_sel == 4'b0); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> region_sel == 4'b0 && !out_of_range && !mode_illegal); // R10

    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !ptr_wb_en); // R10

    AST_PORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_mode == 3'd5 |-> region_sel == 4'b0010); // R7

    AST_OFS_X_BAD: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_mode == 3'd2 && ptr_sel == 2'd0 |-> mode_illegal && region_sel == 4'b0); // R3

    AST_PREDEC_WB: assert property (@(posedge clk) disable iff (rst)
        legal_acc && acc_mode == 3'd3 |=> ptr_wb_en && ptr_wb_val == $past(eff_addr)); // R4

    AST_POSTINC_WB: assert property (@(posedge clk) disable iff (rst)
        legal_acc && acc_mode == 3'd4 |=> ptr_wb_en && ptr_wb_val == $past(ptr_val) + 16'd1); // R5

    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (acc_mode <= 3'd2 || acc_mode == 3'd5) |=> !ptr_wb_en); // R6

    AST_RSV_BAD: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_mode >= 3'd6 |-> mode_illegal && region_sel == 4'b0 && !out_of_range); // R11
endmodule

bind data_addr_gen data_addr_gen_chk #(.SRAM_BYTES(SRAM_BYTES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_mode     (acc_mode),
    .ptr_sel      (ptr_sel),
    .ptr_val      (ptr_val),
    .eff_addr     (eff_addr),
    .region_sel   (region_sel),
    .out_of_range (out_of_range),
    .mode_illegal (mode_illegal),
    .ptr_wb_en    (ptr_wb_en),
    .ptr_wb_val   (ptr_wb_val)
);

// File: tb/data_addr_gen_tb.sv
module data_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [2:0]  acc_mode;
    logic [15:0] abs_addr;
    logic [5:0]  imm6;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_val;
    logic [15:0] eff_addr;
    logic [3:0]  region_sel;
    logic        out_of_range;
    logic        mode_illegal;
    logic        ptr_wb_en;
    logic [1:0]  ptr_wb_sel;
    logic [4:0]  ptr_wb_reg;
    logic [15:0] ptr_wb_val;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [3:0] RG_NONE = 4'b0000, RG_REG = 4'b0001, RG_IO = 4'b0010,
                           RG_XIO = 4'b0100, RG_RAM = 4'b1000;

    always #2 clk = ~clk;

    data_addr_gen #(.SRAM_BYTES(2048)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .abs_addr(abs_addr), .imm6(imm6), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
        .eff_addr(eff_addr), .region_sel(region_sel), .out_of_range(out_of_range),
        .mode_illegal(mode_illegal), .ptr_wb_en(ptr_wb_en), .ptr_wb_sel(ptr_wb_sel),
        .ptr_wb_reg(ptr_wb_reg), .ptr_wb_val(ptr_wb_val)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access: comb outputs checked mid-cycle, write-back checked one cycle later
    task automatic run(input string req, input logic [2:0] m, input logic [1:0] s,
                       input logic [15:0] p, input logic [15:0] a, input logic [5:0] i,
                       input logic [15:0] x_ea, input logic [3:0] x_rg, input logic x_oor,
                       input logic x_ill, input logic x_wb, input logic [15:0] x_wbv,
                       input logic [4:0] x_wbr);
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = m; ptr_sel = s; ptr_val = p; abs_addr = a; imm6 = i;
        #1;
        if (!x_ill) chk(req, "eff_addr", 32'(eff_addr), 32'(x_ea));
        chk(req, "region_sel", 32'(region_sel), 32'(x_rg));
        chk(req, "out_of_range", 32'(out_of_range), 32'(x_oor));
        chk(req, "mode_illegal", 32'(mode_illegal), 32'(x_ill));
        @(negedge clk);
        chk(req, "ptr_wb_en", 32'(ptr_wb_en), 32'(x_wb));
        if (x_wb) begin
            chk(req, "ptr_wb_val", 32'(ptr_wb_val), 32'(x_wbv));
            chk(req, "ptr_wb_reg", 32'(ptr_wb_reg), 32'(x_wbr));
            chk(req, "ptr_wb_sel", 32'(ptr_wb_sel), 32'(s));
        end
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R6", "wb_en after reset", 32'(ptr_wb_en), 0);
        chk("R10", "region idle", 32'(region_sel), 0);
    endtask

    task automatic t_abs();
        run("R1 R8", 3'd0, 2'd3, 16'h1234, 16'h001F, 6'd0, 16'h001F, RG_REG, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd0, 16'h0000, 16'h0020, 6'd9, 16'h0020, RG_IO, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd1, 16'hFFFF, 16'h005F, 6'd0, 16'h005F, RG_IO, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd2, 16'h0000, 16'h0060, 6'd0, 16'h0060, RG_XIO, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd0, 16'h0000, 16'h00FF, 6'd0, 16'h00FF, RG_XIO, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd0, 16'h0000, 16'h0100, 6'd0, 16'h0100, RG_RAM, 0, 0, 0, 0, 0);
        run("R1 R8", 3'd0, 2'd0, 16'h0000, 16'h08FF, 6'd0, 16'h08FF, RG_RAM, 0, 0, 0, 0, 0);
        run("R1 R9", 3'd0, 2'd0, 16'h0000, 16'h0900, 6'd0, 16'h0900, RG_NONE, 1, 0, 0, 0, 0);
        run("R1 R9", 3'd0, 2'd0, 16'h0000, 16'hFFFF, 6'd0, 16'hFFFF, RG_NONE, 1, 0, 0, 0, 0);
    endtask

    task automatic t_ptr();
        run("R2", 3'd1, 2'd1, 16'h0230, 16'h0000, 6'd5, 16'h0230, RG_RAM, 0, 0, 0, 0, 0);
        run("R2", 3'd1, 2'd0, 16'h0003, 16'h0500, 6'd0, 16'h0003, RG_REG, 0, 0, 0, 0, 0);
    endtask

    task automatic t_ofs();
        run("R3", 3'd2, 2'd2, 16'h08C1, 16'h0000, 6'd63, 16'h0900, RG_NONE, 1, 0, 0, 0, 0);
        run("R3", 3'd2, 2'd1, 16'h005F, 16'h0000, 6'd1, 16'h0060, RG_XIO, 0, 0, 0, 0, 0);
        run("R3", 3'd2, 2'd2, 16'hFFF0, 16'h0000, 6'd63, 16'h002F, RG_IO, 0, 0, 0, 0, 0);
        run("R3", 3'd2, 2'd0, 16'h0100, 16'h0000, 6'd4, 16'h0000, RG_NONE, 0, 1, 0, 0, 0);
    endtask

    task automatic t_predec();
        run("R4 R6", 3'd3, 2'd0, 16'h0100, 16'h0000, 6'd0, 16'h00FF, RG_XIO, 0, 0, 1, 16'h00FF, 5'd26);
        run("R4 R9", 3'd3, 2'd1, 16'h0000, 16'h0000, 6'd0, 16'hFFFF, RG_NONE, 1, 0, 1, 16'hFFFF, 5'd28);
    endtask

    task automatic t_postinc();
        run("R5 R6", 3'd4, 2'd2, 16'hFFFF, 16'h0000, 6'd0, 16'hFFFF, RG_NONE, 1, 0, 1, 16'h0000, 5'd30);
        run("R5 R6", 3'd4, 2'd1, 16'h0020, 16'h0000, 6'd0, 16'h0020, RG_IO, 0, 0, 1, 16'h0021, 5'd28);
        // strobe lasts one cycle only
        @(negedge clk);
        chk("R6", "wb_en single cycle", 32'(ptr_wb_en), 0);
    endtask

    task automatic t_port();
        run("R7", 3'd5, 2'd3, 16'hABCD, 16'h0400, 6'd0, 16'h0020, RG_IO, 0, 0, 0, 0, 0);
        run("R7", 3'd5, 2'd0, 16'h0000, 16'h0000, 6'd63, 16'h005F, RG_IO, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reserved();
        run("R11", 3'd6, 2'd0, 16'h0100, 16'h0100, 6'd0, 16'h0000, RG_NONE, 0, 1, 0, 0, 0);
        run("R11", 3'd7, 2'd1, 16'h0100, 16'h0100, 6'd0, 16'h0000, RG_NONE, 0, 1, 0, 0, 0);
        run("R11", 3'd4, 2'd3, 16'h0100, 16'h0000, 6'd0, 16'h0000, RG_NONE, 0, 1, 0, 0, 0);
        run("R11", 3'd1, 2'd3, 16'h0100, 16'h0000, 6'd0, 16'h0000, RG_NONE, 0, 1, 0, 0, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_mode = 3'd4; ptr_sel = 2'd0; ptr_val = 16'h0200; abs_addr = 16'h0010;
        #1;
        chk("R10", "region idle", 32'(region_sel), 0);
        chk("R10", "oor idle", 32'(out_of_range), 0);
        chk("R10", "illegal idle", 32'(mode_illegal), 0);
        @(negedge clk);
        chk("R10", "no wb after idle", 32'(ptr_wb_en), 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_mode = 3'd0; abs_addr = '0;
        imm6 = '0; ptr_sel = '0; ptr_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_abs();
        t_ptr();
        t_ofs();
        t_predec();
        t_postinc();
        t_port();
        t_reserved();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule